// File: doc/BRIEF.md
# Text Overlay Character Renderer

This block paints a text overlay onto a video raster. A timing block supplies the current pixel and line numbers. The renderer turns them into a text cell position and reads that cell's 16-bit word from a synchronous video RAM. It decodes the word in one of two formats, looks up the matching glyph row in a synchronous character-pattern ROM, and applies the cell's attributes. For every pixel it drives a 3-bit colour and a blank signal that switches an external video multiplexer to the overlay.

In attribute mode, each RAM word describes one cell: a glyph code and the cell's own foreground colour and style bits. Control words change the background colour and the transparency. In caption mode, each word packs two 8-bit cells. Style changes come only from control bytes, which act from their cell rightward along the row. The glyph set holds 512 patterns in two banks of 256. The cell height is 16 or 18 scan lines, chosen by an input. Each glyph row is 12 pixels wide. The text window is 16 cells by 4 rows, and its left edge moves right by a programmable offset.

Top module: `ovl_render`

## Requirements
- R1: In attribute mode (`cc_mode`=0) the cell at text row t, column c reads word t*16+c. With bit 15 clear, bits 8:0 give the glyph code, bits 11:9 the foreground colour, bit 12 underline, bit 13 italic and bit 14 blink, all taking effect for that cell alone.
- R2: In caption mode (`cc_mode`=1) the cell at text row t, column c reads word t*8+c/2. Even columns use bits 15:8 and odd columns use bits 7:0.
- R3: A caption byte whose bits 7:5 are 000 is a control byte and shows as background. Bits 4:3 pick the action: 0 sets the foreground to bits 2:0, 1 sets the background to bits 2:0, 2 sets {blink, underline, italic} from bits 2:0, and 3 sets transparent from bit 0 and the bank from bit 1. The effect lasts for the following cells of that line. Every line starts from foreground 7, background 0, all flags clear and bank 0.
- R4: The glyph ROM address is {bank, code[7:0], glyph row[4:0]}, where the bank comes from word bit 8 in attribute mode and from the caption state in caption mode.
- R5: With `tall`=1 cells are 18 lines high, otherwise 16. The text row is line/height and the glyph row is line modulo height.
- R6: The window starts at pixel `offset` and spans 16 cells of 12 pixels on text rows 0 to 3. Outside it, `blank`=0 and `rgb`=0.
- R7: Glyph-row bit 11 is the leftmost pixel. A set pixel drives `blank`=1 with the foreground colour, and a clear pixel drives the background colour. The output for a pixel appears three clock edges after its position is presented.
- R8: Italic shifts the glyph row right by (height-1-row)/4 pixels, filling with zeros.
- R9: Underline forces every pixel of the last glyph row of the cell to foreground.
- R10: While `blink_on`=0, the foreground pixels of a blinking cell show as background.
- R11: When transparency is on, background pixels drive `blank`=0 and `rgb`=0.
- R12: In attribute mode a word with bit 15 set is a control word. It shows as background and sets the background colour from bits 2:0 and transparency from bit 3 for itself and the following cells of that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_x | input | 10 | Current pixel number on the line |
| line_y | input | 9 | Current line number |
| offset | input | 6 | Left edge of the text window in pixels |
| cc_mode | input | 1 | 1 = caption format, 0 = attribute format |
| tall | input | 1 | 1 = 18-line cells, 0 = 16-line cells |
| blink_on | input | 1 | Blink timebase phase, 1 = visible |
| vram_addr | output | 6 | Video RAM word address |
| vram_rdata | input | 16 | Video RAM data, one cycle after the address |
| rom_addr | output | 14 | Glyph ROM address |
| rom_rdata | input | 12 | Glyph ROM row, one cycle after the address |
| rgb | output | 3 | Overlay colour |
| blank | output | 1 | Selects the overlay at the video multiplexer |

## Verification
Whole scan lines are swept pixel by pixel and compared with a model built from the requirements. The first memory image gives each attribute-mode cell a different colour, italic, underline, blink and bank bit. It tells per-cell attributes apart from attributes that persist. The caption image mixes control bytes of all four kinds with printable bytes, which separates byte order, attribute carry along a line and the reset at the line start. The third image mixes control words that are and are not transparent. Lines are chosen on the last glyph row, near the top of a cell where the italic shift is largest, in both cell heights, and below the window, with several offsets and both blink phases.

// File: rtl/ovl_pkg.sv
// Shared types and constants for the text overlay renderer.
// Assumes the glyph row index always fits in five bits (cells of 16 or 18 lines).
package ovl_pkg;

    // Running attribute state of one cell.
    typedef struct packed {
        logic [2:0] fg;
        logic [2:0] bg;
        logic       ul;
        logic       it;
        logic       bl;
        logic       tr;
        logic       bank;
    } attr_t;

    localparam attr_t ATTR_RESET = '{fg: 3'd7, bg: 3'd0, ul: 1'b0, it: 1'b0,
                                     bl: 1'b0, tr: 1'b0, bank: 1'b0};

    localparam int ROW_SHORT = 16;
    localparam int ROW_TALL  = 18;
    localparam int ROWW      = 5;
    localparam int CODEW     = 9;

endpackage

// File: rtl/ovl_locate.sv
// Position decoder: maps a pixel and line number onto a text cell, the pixel
// inside the cell, the glyph row, and the video RAM word to fetch.
// Assumes the text window is COLS cells of GW pixels on TROWS rows; it is
// purely combinational and constant divisors keep the dividers small.
module ovl_locate
    import ovl_pkg::*;
#(
    parameter int GW    = 12,
    parameter int COLS  = 16,
    parameter int TROWS = 4,
    parameter int XW    = 10,
    parameter int YW    = 9,
    parameter int OFFW  = 6,
    localparam int CW   = $clog2(COLS),
    localparam int PXW  = $clog2(GW),
    localparam int VAW  = $clog2(TROWS * COLS)
) (
    input  logic [XW-1:0]   pix_x,
    input  logic [YW-1:0]   line_y,
    input  logic [OFFW-1:0] offset,
    input  logic            cc_mode,
    input  logic            tall,
    output logic            win,
    output logic [CW-1:0]   col,
    output logic [PXW-1:0]  px,
    output logic [ROWW-1:0] grow,
    output logic [VAW-1:0]  vram_addr
);

    logic [31:0] xr, colw, pxw, trw, grw, addrw;

    // Split position into cell, pixel, text row, glyph row and word address.
    always_comb begin
        xr    = 32'(pix_x) - 32'(offset);
        colw  = xr / GW;
        pxw   = xr % GW;
        trw   = tall ? 32'(line_y) / ROW_TALL : 32'(line_y) / ROW_SHORT;
        grw   = tall ? 32'(line_y) % ROW_TALL : 32'(line_y) % ROW_SHORT;
        win   = (32'(pix_x) >= 32'(offset)) && (colw < COLS) && (trw < TROWS);
        addrw = cc_mode ? trw * (COLS / 2) + colw / 2 : trw * COLS + colw;
        col       = colw[CW-1:0];
        px        = pxw[PXW-1:0];
        grow      = grw[ROWW-1:0];
        vram_addr = addrw[VAW-1:0];
    end

endmodule

// File: rtl/ovl_decode.sv
// Word decoder and attribute tracker: interprets the fetched RAM word in the
// selected format, applies control codes to the running attribute state and
// yields the glyph code. The state restarts at column 0 of every line.
// Assumes a cell's word is presented for every pixel of the cell.
module ovl_decode
    import ovl_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win,
    input  logic [CW-1:0]    col,
    input  logic             cc_mode,
    input  logic [15:0]      word,
    output attr_t            attr,
    output logic             ctrl,
    output logic [CODEW-1:0] glyph
);

    attr_t      attr_q;
    logic [7:0] cbyte;

    // Decode the cell and apply any control code on top of the carried state.
    always_comb begin
        attr  = (col == '0) ? ATTR_RESET : attr_q;
        ctrl  = 1'b0;
        glyph = '0;
        cbyte = col[0] ? word[7:0] : word[15:8];
        if (cc_mode) begin
            if (cbyte[7:5] == 3'b000) begin
                ctrl = 1'b1;
                case (cbyte[4:3])
                    2'd0: attr.fg = cbyte[2:0];
                    2'd1: attr.bg = cbyte[2:0];
                    2'd2: {attr.bl, attr.ul, attr.it} = cbyte[2:0];
                    default: begin
                        attr.tr   = cbyte[0];
                        attr.bank = cbyte[1];
                    end
                endcase
            end else begin
                glyph = {attr.bank, cbyte};
            end
        end else if (word[15]) begin
            ctrl    = 1'b1;
            attr.bg = word[2:0];
            attr.tr = word[3];
        end else begin
            glyph   = word[8:0];
            attr.fg = word[11:9];
            attr.ul = word[12];
            attr.it = word[13];
            attr.bl = word[14];
        end
    end

    // Carry the attribute state from pixel to pixel along the line.
    always_ff @(posedge clk) begin
        if (!rst_n)   attr_q <= ATTR_RESET;
        else if (win) attr_q <= attr;
    end

endmodule

// File: rtl/ovl_shade.sv
// Pixel shader: picks the pixel from the glyph row, applies italic shift,
// underline, blink and transparency, and registers colour and blank.
// Assumes px is below GW whenever win is set.
module ovl_shade
    import ovl_pkg::*;
#(
    parameter int GW  = 12,
    localparam int PXW = $clog2(GW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            win,
    input  logic            ctrl,
    input  attr_t           attr,
    input  logic [PXW-1:0]  px,
    input  logic [ROWW-1:0] grow,
    input  logic            tall,
    input  logic [GW-1:0]   bits,
    input  logic            blink_on,
    output logic [2:0]      rgb,
    output logic            blank
);

    logic [ROWW-1:0] last_row, shift;
    logic [GW-1:0]   shifted;
    logic [31:0]     idx;
    logic            on;

    // Decide whether this pixel is foreground.
    always_comb begin
        last_row = tall ? ROWW'(ROW_TALL - 1) : ROWW'(ROW_SHORT - 1);
        shift    = attr.it ? (last_row - grow) >> 2 : '0;
        shifted  = bits >> shift;
        idx      = 32'(GW - 1) - 32'(px);
        on       = shifted[idx[PXW-1:0]];
        if (attr.ul && grow == last_row) on = 1'b1;
        if (ctrl) on = 1'b0;
        if (attr.bl && !blink_on) on = 1'b0;
    end

    // Register the overlay colour and the multiplexer select.
    always_ff @(posedge clk) begin
        if (!rst_n || !win) begin
            rgb   <= '0;
            blank <= 1'b0;
        end else if (on) begin
            rgb   <= attr.fg;
            blank <= 1'b1;
        end else if (attr.tr) begin
            rgb   <= '0;
            blank <= 1'b0;
        end else begin
            rgb   <= attr.bg;
            blank <= 1'b1;
        end
    end

endmodule

// File: rtl/ovl_render.sv
// Text overlay renderer top: three-stage pipeline of position decode with the
// RAM fetch, word decode with the glyph fetch, and pixel shading.
// Assumes both memories return data one clock after the address.
module ovl_render
    import ovl_pkg::*;
#(
    parameter int GW    = 12,
    parameter int COLS  = 16,
    parameter int TROWS = 4,
    parameter int XW    = 10,
    parameter int YW    = 9,
    parameter int OFFW  = 6,
    localparam int CW   = $clog2(COLS),
    localparam int PXW  = $clog2(GW),
    localparam int VAW  = $clog2(TROWS * COLS),
    localparam int RAW  = CODEW + ROWW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XW-1:0]   pix_x,
    input  logic [YW-1:0]   line_y,
    input  logic [OFFW-1:0] offset,
    input  logic            cc_mode,
    input  logic            tall,
    input  logic            blink_on,
    output logic [VAW-1:0]  vram_addr,
    input  logic [15:0]     vram_rdata,
    output logic [RAW-1:0]  rom_addr,
    input  logic [GW-1:0]   rom_rdata,
    output logic [2:0]      rgb,
    output logic            blank
);

    logic            loc_win;
    logic [CW-1:0]   loc_col;
    logic [PXW-1:0]  loc_px;
    logic [ROWW-1:0] loc_grow;

    logic            s1_win, s1_cc, s1_tall;
    logic [CW-1:0]   s1_col;
    logic [PXW-1:0]  s1_px;
    logic [ROWW-1:0] s1_grow;

    attr_t            dec_attr;
    logic             dec_ctrl;
    logic [CODEW-1:0] dec_glyph;

    logic            s2_win, s2_ctrl, s2_tall;
    attr_t           s2_attr;
    logic [PXW-1:0]  s2_px;
    logic [ROWW-1:0] s2_grow;

    ovl_locate #(.GW(GW), .COLS(COLS), .TROWS(TROWS), .XW(XW), .YW(YW), .OFFW(OFFW)) u_locate (
        .pix_x(pix_x), .line_y(line_y), .offset(offset), .cc_mode(cc_mode), .tall(tall),
        .win(loc_win), .col(loc_col), .px(loc_px), .grow(loc_grow), .vram_addr(vram_addr)
    );

    // Stage 1: hold the position while the RAM word is read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_win <= 1'b0; s1_cc <= 1'b0; s1_tall <= 1'b0;
            s1_col <= '0;   s1_px <= '0;   s1_grow <= '0;
        end else begin
            s1_win <= loc_win; s1_cc <= cc_mode; s1_tall <= tall;
            s1_col <= loc_col; s1_px <= loc_px;  s1_grow <= loc_grow;
        end
    end

    ovl_decode #(.CW(CW)) u_decode (
        .clk(clk), .rst_n(rst_n), .win(s1_win), .col(s1_col), .cc_mode(s1_cc),
        .word(vram_rdata), .attr(dec_attr), .ctrl(dec_ctrl), .glyph(dec_glyph)
    );

    assign rom_addr = {dec_glyph, s1_grow};

    // Stage 2: hold the decoded cell while the glyph row is read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_win <= 1'b0; s2_ctrl <= 1'b0; s2_tall <= 1'b0;
            s2_attr <= ATTR_RESET; s2_px <= '0; s2_grow <= '0;
        end else begin
            s2_win <= s1_win; s2_ctrl <= dec_ctrl; s2_tall <= s1_tall;
            s2_attr <= dec_attr; s2_px <= s1_px; s2_grow <= s1_grow;
        end
    end

    ovl_shade #(.GW(GW)) u_shade (
        .clk(clk), .rst_n(rst_n), .win(s2_win), .ctrl(s2_ctrl), .attr(s2_attr),
        .px(s2_px), .grow(s2_grow), .tall(s2_tall), .bits(rom_rdata),
        .blink_on(blink_on), .rgb(rgb), .blank(blank)
    );

endmodule

// File: rtl/ovl_render_chk.sv
// Checker for the overlay renderer, bound to every ovl_render instance.
// Assumes the pipeline stage names of the top module.
module ovl_render_chk
    import ovl_pkg::*;
#(
    parameter int COLS  = 16,
    parameter int TROWS = 4,
    localparam int VAW  = $clog2(TROWS * COLS)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cc_mode,
    input logic           loc_win,
    input logic [VAW-1:0] vram_addr,
    input logic           s1_win,
    input logic           s1_tall,
    input logic [13:0]    rom_addr,
    input logic           s2_win,
    input logic           s2_ctrl,
    input attr_t          s2_attr,
    input logic           blink_on,
    input logic [2:0]     rgb,
    input logic           blank
);

    a_r6_outside_dark: assert property (@(posedge clk) disable iff (!rst_n)
        !s2_win |=> (!blank && rgb == 3'd0));

    a_r2_caption_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_mode && loc_win) |-> (32'(vram_addr) < (TROWS * COLS) / 2));

    a_r5_row_in_cell: assert property (@(posedge clk) disable iff (!rst_n)
        s1_win |-> (rom_addr[4:0] < (s1_tall ? 5'd18 : 5'd16)));

    a_r11_ctrl_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_win && s2_ctrl && s2_attr.tr) |=> !blank);

    a_r12_ctrl_bg: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_win && s2_ctrl && !s2_attr.tr) |=> (blank && rgb == $past(s2_attr.bg)));

    a_r10_blink_hide: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_win && s2_attr.bl && !blink_on && !s2_attr.tr) |=> (blank && rgb == $past(s2_attr.bg)));

endmodule

bind ovl_render ovl_render_chk #(.COLS(COLS), .TROWS(TROWS)) u_chk (
    .clk(clk), .rst_n(rst_n), .cc_mode(cc_mode), .loc_win(loc_win),
    .vram_addr(vram_addr), .s1_win(s1_win), .s1_tall(s1_tall), .rom_addr(rom_addr),
    .s2_win(s2_win), .s2_ctrl(s2_ctrl), .s2_attr(s2_attr), .blink_on(blink_on),
    .rgb(rgb), .blank(blank)
);

// File: tb/sim_ovl_render.sv
// Bench for ovl_render: sweeps whole lines against a requirement model.
module sim_ovl_render;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  pix_x = '0;
    logic [8:0]  line_y = '0;
    logic [5:0]  offset = '0;
    logic        cc_mode = 1'b0, tall = 1'b0, blink_on = 1'b1;
    logic [5:0]  vram_addr;
    logic [15:0] vram_rdata;
    logic [13:0] rom_addr;
    logic [11:0] rom_rdata;
    logic [2:0]  rgb;
    logic        blank;

    logic [15:0] vram [64];
    int errors = 0, checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ovl_render u0 (.clk(clk), .rst_n(rst_n), .pix_x(pix_x), .line_y(line_y), .offset(offset),
        .cc_mode(cc_mode), .tall(tall), .blink_on(blink_on), .vram_addr(vram_addr),
        .vram_rdata(vram_rdata), .rom_addr(rom_addr), .rom_rdata(rom_rdata),
        .rgb(rgb), .blank(blank));

    function automatic logic [11:0] rom_fn(logic [13:0] a);
        return 12'(({3'b0, a[13:5]} * 12'd37) ^ ({7'b0, a[4:0]} * 12'd149)) ^ {a[13], 11'b0};
    endfunction

    // Synchronous memory models.
    always_ff @(posedge clk) begin
        vram_rdata <= vram[vram_addr];
        rom_rdata  <= rom_fn(rom_addr);
    end

    typedef struct packed {
        logic [1:0] set; logic cc; logic tall; logic blink; logic [5:0] off; logic [8:0] y;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 1'b0, 1'b1, 6'd0, 9'd3},   // R1 R7 R8
        '{2'd0, 1'b0, 1'b0, 1'b0, 6'd5, 9'd15},  // R6 R9 R10
        '{2'd0, 1'b0, 1'b1, 1'b1, 6'd2, 9'd17},  // R5 R9
        '{2'd0, 1'b0, 1'b1, 1'b1, 6'd0, 9'd20},  // R4 R5
        '{2'd1, 1'b1, 1'b0, 1'b1, 6'd0, 9'd1},   // R2 R3
        '{2'd1, 1'b1, 1'b0, 1'b0, 6'd7, 9'd35},  // R3 R10
        '{2'd2, 1'b0, 1'b0, 1'b1, 6'd3, 9'd8},   // R11 R12
        '{2'd0, 1'b0, 1'b0, 1'b1, 6'd0, 9'd70},  // R6
        '{2'd1, 1'b1, 1'b1, 1'b1, 6'd1, 9'd71},  // R2 R5
        '{2'd2, 1'b0, 1'b1, 1'b0, 6'd0, 9'd40}   // R11 R12
    };

    function automatic string vec_tag(int v);
        case (v)
            0: return "R1/R7/R8";  1: return "R6/R9/R10"; 2: return "R5/R9";
            3: return "R4/R5";     4: return "R2/R3";     5: return "R3/R10";
            6: return "R11/R12";   7: return "R6";        8: return "R2/R5";
            default: return "R11/R12";
        endcase
    endfunction

    function automatic logic [7:0] cc_byte(int k);
        if (k % 5 == 1) return {3'b000, 2'(k % 4), 3'((k * 3) % 8)};
        return 8'(32 + (k * 11) % 224);
    endfunction

    function automatic logic [15:0] attr_word(int i);
        return {1'b0, 1'(i % 5 == 0), 1'(i % 3 == 0), 1'(i % 4 == 1), 3'(i % 8),
                9'((i * 37) % 256 + (i % 2) * 256)};
    endfunction

    task automatic fill(input logic [1:0] s);
        for (int i = 0; i < 64; i++) begin
            case (s)
                2'd0: vram[i] = attr_word(i);
                2'd1: vram[i] = {cc_byte(2 * i), cc_byte(2 * i + 1)};
                default: vram[i] = (i % 3 == 0) ? {1'b1, 11'b0, 1'(i % 2), 3'(i % 8)} : attr_word(i);
            endcase
        end
    endtask

    // Model of the requirements: returns {blank, rgb} for one pixel.
    function automatic logic [3:0] model(int x, int y);
        int h, xr, c0, p, tr_, gr, sh;
        logic [2:0] fg, bg; logic ul, it, bl, trn, bank, ctl;
        logic [8:0] g; logic [15:0] w; logic [7:0] b; logic [11:0] bits; logic on;
        h = tall ? 18 : 16;
        if (x < int'(offset)) return 4'd0;
        xr = x - int'(offset); c0 = xr / 12; p = xr % 12; tr_ = y / h; gr = y % h;
        if (c0 >= 16 || tr_ >= 4) return 4'd0;
        fg = 3'd7; bg = 3'd0; ul = 0; it = 0; bl = 0; trn = 0; bank = 0; ctl = 0; g = '0;
        for (int c = 0; c <= c0; c++) begin
            if (cc_mode) begin
                w = vram[tr_ * 8 + c / 2];
                b = (c % 2 == 1) ? w[7:0] : w[15:8];
                ctl = (b[7:5] == 3'b000);
                if (ctl) begin
                    case (b[4:3])
                        2'd0: fg = b[2:0];
                        2'd1: bg = b[2:0];
                        2'd2: begin bl = b[2]; ul = b[1]; it = b[0]; end
                        default: begin trn = b[0]; bank = b[1]; end
                    endcase
                end else g = {bank, b};
            end else begin
                w = vram[tr_ * 16 + c];
                ctl = w[15];
                if (ctl) begin bg = w[2:0]; trn = w[3]; end
                else begin g = w[8:0]; fg = w[11:9]; ul = w[12]; it = w[13]; bl = w[14]; end
            end
        end
        bits = rom_fn({g, 5'(gr)});
        sh = it ? (h - 1 - gr) / 4 : 0;
        bits = bits >> sh;
        on = bits[11 - p];
        if (ul && gr == h - 1) on = 1'b1;
        if (ctl) on = 1'b0;
        if (bl && !blink_on) on = 1'b0;
        if (on) return {1'b1, fg};
        if (trn) return 4'd0;
        return {1'b1, bg};
    endfunction

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp, input int x);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s x=%0d y=%0d: actual blank/rgb=%h expected=%h", tag, x, line_y, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R7 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        fill(2'd0);
        // Reset state: window pixel presented while in reset stays dark (R6, R7).
        pix_x = 10'd20; line_y = 9'd2;
        repeat (5) @(negedge clk);
        check("R7 reset", {blank, rgb}, 4'd0, 20);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 first edge after reset", {blank, rgb}, 4'd0, 20);

        // Vector walk: one whole line per entry.
        for (int v = 0; v < NV; v++) begin
            fill(VECS[v].set);
            cc_mode = VECS[v].cc; tall = VECS[v].tall; blink_on = VECS[v].blink;
            offset = VECS[v].off; line_y = VECS[v].y;
            for (int i = 0; i < 6 + 16 * 12 + 6; i++) begin
                @(negedge clk);
                if (i >= 3) check(vec_tag(v), {blank, rgb}, model(i - 3, int'(line_y)), i - 3);
                pix_x = 10'(i);
            end
        end

        // Directed: caption control at column 0 turns the whole line transparent (R3, R11).
        cc_mode = 1'b1; tall = 1'b0; blink_on = 1'b1; offset = 6'd0; line_y = 9'd0;
        for (int i = 0; i < 8; i++) vram[i] = {8'h19, 8'h00};
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (i >= 15) check("R3 R11 transparent row", {blank, rgb}, model(i - 3, 0), i - 3);
            pix_x = 10'(i);
        end
        // Directed: underline line on last row overrides glyph bits (R9).
        cc_mode = 1'b0; line_y = 9'd15;
        for (int i = 0; i < 16; i++) vram[i] = 16'h1000 | 16'(i << 9) | 16'h0041;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (i >= 3) check("R9 underline", {blank, rgb}, {1'b1, 3'((i - 3) / 12)}, i - 3);
            pix_x = 10'(i);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule